// File: doc/BRIEF.md
# Serial Flash Sequence Engine

This block drives a single-lane SPI NOR flash from a small table of micro-instructions that software writes. Each table entry describes one flash transaction: an opcode byte, an optional address, idle clocks, and a data phase that reads or writes bytes. The host writes the flash address, then writes a command word that selects a table sequence and can set a byte count. The engine runs that sequence on the serial pins and sets a busy flag until the sequence is done.

A key-and-command step protects the table. Until that step unlocks it, the table ignores writes. Read data is packed into a 128-byte receive buffer that the host reads one 32-bit word at a time. Write data comes from a 64-byte transmit buffer that the host fills one 32-bit word at a time. Each buffer has its own clear bit.

The register map below uses word addresses on an 8-bit register bus. The lock key is the `LOCK_KEY` parameter, which defaults to 32'h5AF0_C3A5.
- 0x00 control: bit 0 clears the receive buffer, bit 1 clears the transmit buffer.
- 0x01 key.
- 0x02 lock control: bit 0 unlocks, bit 1 locks, and lock takes priority.
- 0x03 flash address.
- 0x04 command: sequence index in bits [19:16], byte count in bits [7:0].
- 0x05 status: bit 0 busy, bit 1 error, bit 2 receive data present, bit 3 table unlocked.
- 0x06 transmit push.
- 0x40–0x7F table words.
- 0x80–0x9F receive words.

Top module: `flash_seq_engine`

## Requirements
- R1: After reset the status reads 0: idle, no error, no receive data, table locked. Chip select is high, the serial clock is low, and every table word reads 0.
- R2: A table write changes the word only while the table is unlocked. Unlocking needs the key written to 0x01 and then lock control written with bit 0 set. A wrong key leaves the table locked. The key followed by lock control with bit 1 set locks the table again.
- R3: Sequence s is held in table words 4s to 4s+3. Slot 2k sits in bits [15:0] of word k and slot 2k+1 sits in bits [31:16]. A slot holds a kind in bits [15:10], a lane code in bits [9:8] and an operand in bits [7:0]. A kind of 0 ends the sequence, and so does reaching the end of slot 7.
- R4: Kind 1 sends the operand as 8 bits, MSB first. Kind 2 sends the low operand-count bits of the flash address register, MSB first.
- R5: Kind 3 gives operand-count serial clocks with the data-out line low.
- R6: Kind 4 reads bytes into the receive buffer. Byte i goes to word i/4 at bit 8*(i%4). Unused bytes of a partly filled word read 0. Status bit 2 is set once any byte is held.
- R7: Kind 5 sends bytes from the transmit buffer. The word pushed first is sent first, starting from its least significant byte. When the buffer is empty, 0x00 bytes are sent.
- R8: A nonzero byte count in the command replaces the read or write length. A count of 0 keeps the operand as the length.
- R9: SPI mode 0 is used, and one bit takes CLK_DIV system clocks. Busy rises on the command write and falls one clock after chip select rises. Chip select stays low for the whole sequence. The serial clock only toggles while chip select is low.
- R10: A command write while busy is ignored and sets status bit 1. That bit stays set until reset.
- R11: The receive clear bit empties the receive buffer. The transmit clear bit empties the transmit buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A flash model in the bench records every bit sent on the data-out line. It returns a known bit stream, so each received byte follows from its bit offset in the frame. Read sequences use a 24-bit address with 8 idle clocks and a 32-bit address with 5 idle clocks. The 5-clock case detects a dummy phase that is counted in bytes instead of clocks. Random addresses and random byte counts from 1 to 128 test the packing and the zero fill of the last word. Other directed runs cover:
- a sequence that fills all 8 slots,
- a one-byte status read,
- a 64-byte program from the transmit buffer,
- a program from an empty transmit buffer,
- a command written while the engine is busy.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [5:0] {
    K_END   = 6'd0,
    K_CMD   = 6'd1,
    K_ADDR  = 6'd2,
    K_DUMMY = 6'd3,
    K_READ  = 6'd4,
    K_WRITE = 6'd5
  } ins_kind_e;

  typedef struct packed {
    ins_kind_e   kind;
    logic [1:0]  lanes;
    logic [7:0]  arg;
  } ins_t;

  localparam logic [7:0] RA_CTRL  = 8'h00;
  localparam logic [7:0] RA_KEY   = 8'h01;
  localparam logic [7:0] RA_LOCK  = 8'h02;
  localparam logic [7:0] RA_FADDR = 8'h03;
  localparam logic [7:0] RA_CMD   = 8'h04;
  localparam logic [7:0] RA_STAT  = 8'h05;
  localparam logic [7:0] RA_TXD   = 8'h06;
endpackage

// File: rtl/flash_lut.sv
module flash_lut #(
  parameter int          NSEQ = 16,
  parameter logic [31:0] KEY  = 32'h5AF0_C3A5,
  parameter int          IW   = $clog2(NSEQ * 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_we,
  input  logic          lock_we,
  input  logic          tab_we,
  input  logic [1:0]    lock_op,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] tab_idx,
  input  logic [IW-1:0] fetch_idx,
  output logic [31:0]   fetch_word,
  output logic [31:0]   host_word,
  output logic          unlocked
);
  localparam int WORDS = NSEQ * 4;

  logic [31:0] tab_q [WORDS];
  logic        key_ok_q, key_ok_d;
  logic        unl_q, unl_d;

  always_comb begin
    key_ok_d = key_ok_q;
    unl_d    = unl_q;
    if (key_we) begin
      key_ok_d = (wdata == KEY);
    end else if (lock_we) begin
      key_ok_d = 1'b0;
      if (key_ok_q) begin
        if (lock_op[1])      unl_d = 1'b0;
        else if (lock_op[0]) unl_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_ok_q <= 1'b0;
      unl_q    <= 1'b0;
    end else begin
      key_ok_q <= key_ok_d;
      unl_q    <= unl_d;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     tab_q[g] <= '0;
      else if (tab_we && unl_q && tab_idx == IW'(g))  tab_q[g] <= wdata;
    end
  end

  assign fetch_word = tab_q[fetch_idx];
  assign host_word  = tab_q[tab_idx];
  assign unlocked   = unl_q;
endmodule

// File: rtl/flash_shifter.sv
module flash_shifter #(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  nbits,
  input  logic [31:0] din,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        done,
  output logic [7:0]  rx_byte
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic          act_q, act_d;
  logic [CW-1:0] div_q, div_d;
  logic [7:0]    bit_q, bit_d;
  logic [31:0]   sh_q, sh_d;
  logic [7:0]    rx_q, rx_d;
  logic          edge_hi, edge_end;

  assign edge_hi  = act_q && (div_q == CW'(HALF - 1));
  assign edge_end = act_q && (div_q == CW'(DIV - 1));
  assign done     = edge_end && (bit_q == 8'd1);

  always_comb begin
    act_d = act_q;
    div_d = div_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    rx_d  = rx_q;
    if (!act_q) begin
      if (start) begin
        act_d = 1'b1;
        div_d = '0;
        bit_d = nbits;
        sh_d  = din;
      end
    end else begin
      div_d = edge_end ? '0 : div_q + 1'b1;
      if (edge_hi) rx_d = {rx_q[6:0], miso};
      if (edge_end) begin
        sh_d  = {sh_q[30:0], 1'b0};
        bit_d = bit_q - 8'd1;
        if (bit_q == 8'd1) act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      div_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      rx_q  <= '0;
    end else begin
      act_q <= act_d;
      div_q <= div_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      rx_q  <= rx_d;
    end
  end

  assign sclk    = act_q && (div_q >= CW'(HALF));
  assign mosi    = act_q && sh_q[31];
  assign rx_byte = rx_q;
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [SW-1:0] go_seq,
  input  logic [7:0]    go_cnt,
  input  logic [31:0]   faddr,
  input  logic [31:0]   lut_word,
  output logic [SW+1:0] lut_idx,
  output logic          sh_start,
  output logic [7:0]    sh_nbits,
  output logic [31:0]   sh_din,
  input  logic          sh_done,
  input  logic [7:0]    tx_byte,
  output logic          rx_push,
  output logic          tx_pop,
  output logic          busy,
  output logic          cs_n
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ISSUE, S_SHIFT, S_END} st_e;

  st_e         st_q, st_d;
  logic [SW-1:0] seq_q, seq_d;
  logic [2:0]  slot_q, slot_d;
  logic [7:0]  cnt_q, cnt_d;
  logic [7:0]  left_q, left_d;
  ins_kind_e   kind_q, kind_d;
  ins_t        ins;
  logic [7:0]  len;
  logic        adv, is_data;

  assign lut_idx = {seq_q, slot_q[2:1]};
  assign ins     = slot_q[0] ? ins_t'(lut_word[31:16]) : ins_t'(lut_word[15:0]);
  assign len     = (cnt_q != 8'd0) ? cnt_q : ins.arg;
  assign is_data = (kind_q == K_READ) || (kind_q == K_WRITE);

  always_comb begin
    st_d     = st_q;
    seq_d    = seq_q;
    slot_d   = slot_q;
    cnt_d    = cnt_q;
    left_d   = left_q;
    kind_d   = kind_q;
    sh_start = 1'b0;
    sh_nbits = 8'd8;
    sh_din   = '0;
    rx_push  = 1'b0;
    tx_pop   = 1'b0;
    adv      = 1'b0;
    case (st_q)
      S_IDLE: if (go) begin
        seq_d  = go_seq;
        cnt_d  = go_cnt;
        slot_d = '0;
        st_d   = S_FETCH;
      end
      S_FETCH: begin
        kind_d = ins.kind;
        case (ins.kind)
          K_CMD: begin
            sh_start = 1'b1;
            sh_din   = {ins.arg, 24'h0};
            st_d     = S_SHIFT;
          end
          K_ADDR, K_DUMMY: begin
            if (ins.arg == 8'd0) adv = 1'b1;
            else begin
              sh_start = 1'b1;
              sh_nbits = ins.arg;
              sh_din   = (ins.kind == K_ADDR) ? faddr << (8'd32 - ins.arg) : 32'h0;
              st_d     = S_SHIFT;
            end
          end
          K_READ, K_WRITE: begin
            if (len == 8'd0) adv = 1'b1;
            else begin
              left_d = len;
              st_d   = S_ISSUE;
            end
          end
          default: st_d = S_END;
        endcase
      end
      S_ISSUE: begin
        sh_start = 1'b1;
        sh_din   = (kind_q == K_WRITE) ? {tx_byte, 24'h0} : 32'h0;
        st_d     = S_SHIFT;
      end
      S_SHIFT: if (sh_done) begin
        rx_push = (kind_q == K_READ);
        tx_pop  = (kind_q == K_WRITE);
        if (is_data && left_q > 8'd1) begin
          left_d = left_q - 8'd1;
          st_d   = S_ISSUE;
        end else adv = 1'b1;
      end
      S_END:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (adv) begin
      if (slot_q == 3'd7) st_d = S_END;
      else begin
        slot_d = slot_q + 3'd1;
        st_d   = S_FETCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      seq_q  <= '0;
      slot_q <= '0;
      cnt_q  <= '0;
      left_q <= '0;
      kind_q <= K_END;
    end else begin
      st_q   <= st_d;
      seq_q  <= seq_d;
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
      kind_q <= kind_d;
    end
  end

  assign busy = (st_q != S_IDLE);
  assign cs_n = (st_q == S_IDLE) || (st_q == S_END);
endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
  import flash_seq_pkg::*;
#(
  parameter int          NSEQ     = 16,
  parameter int          CLK_DIV  = 4,
  parameter int          RX_BYTES = 128,
  parameter int          TX_BYTES = 64,
  parameter logic [31:0] LOCK_KEY = 32'h5AF0_C3A5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int SW  = $clog2(NSEQ);
  localparam int IW  = SW + 2;
  localparam int RXW = RX_BYTES / 4;
  localparam int TXW = TX_BYTES / 4;
  localparam int RBW = $clog2(RX_BYTES);
  localparam int TBW = $clog2(TX_BYTES);

  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic cmd_we, busy, go, err_q, err_d, unlocked;
  logic tab_sel, rx_sel, rx_clr, tx_clr, tx_push;
  logic [31:0] faddr_q, faddr_d, lut_fetch, lut_host;
  logic [IW-1:0] lut_idx;
  logic sh_start, sh_done, rx_push, tx_pop;
  logic [7:0] sh_nbits, rx_byte, tx_byte;
  logic [31:0] sh_din;

  assign tab_sel = (reg_addr[7:6] == 2'b01);
  assign rx_sel  = (reg_addr[7:5] == 3'b100);
  assign cmd_we  = reg_we && (reg_addr == RA_CMD);
  assign go      = cmd_we && !busy;
  assign err_d   = err_q || (cmd_we && busy);
  assign rx_clr  = reg_we && (reg_addr == RA_CTRL) && reg_wdata[0];
  assign tx_clr  = reg_we && (reg_addr == RA_CTRL) && reg_wdata[1];
  assign tx_push = reg_we && (reg_addr == RA_TXD);
  assign faddr_d = (reg_we && reg_addr == RA_FADDR) ? reg_wdata : faddr_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      err_q   <= 1'b0;
      faddr_q <= '0;
    end else begin
      err_q   <= err_d;
      faddr_q <= faddr_d;
    end
  end

  flash_lut #(.NSEQ(NSEQ), .KEY(LOCK_KEY), .IW(IW)) u_lut (
    .clk(clk), .rst_n(rst_s),
    .key_we(reg_we && reg_addr == RA_KEY),
    .lock_we(reg_we && reg_addr == RA_LOCK),
    .tab_we(reg_we && tab_sel),
    .lock_op(reg_wdata[1:0]), .wdata(reg_wdata),
    .tab_idx(reg_addr[IW-1:0]), .fetch_idx(lut_idx),
    .fetch_word(lut_fetch), .host_word(lut_host), .unlocked(unlocked)
  );

  flash_seq_ctrl #(.SW(SW)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .go(go),
    .go_seq(reg_wdata[16 +: SW]), .go_cnt(reg_wdata[7:0]),
    .faddr(faddr_q), .lut_word(lut_fetch), .lut_idx(lut_idx),
    .sh_start(sh_start), .sh_nbits(sh_nbits), .sh_din(sh_din), .sh_done(sh_done),
    .tx_byte(tx_byte), .rx_push(rx_push), .tx_pop(tx_pop),
    .busy(busy), .cs_n(spi_cs_n)
  );

  flash_shifter #(.DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_s), .start(sh_start), .nbits(sh_nbits), .din(sh_din),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done), .rx_byte(rx_byte)
  );

  // receive buffer: byte pointer, words packed low byte first
  logic [31:0] rx_mem [RXW];
  logic [RBW:0] rx_ptr_q, rx_ptr_d;
  logic rx_wr;
  assign rx_wr    = rx_push && !rx_ptr_q[RBW] && !rx_clr;
  assign rx_ptr_d = rx_clr ? '0 : (rx_wr ? rx_ptr_q + 1'b1 : rx_ptr_q);

  for (genvar g = 0; g < RXW; g++) begin : g_rx
    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) rx_mem[g] <= '0;
      else if (rx_wr && rx_ptr_q[RBW-1:2] == (RBW-2)'(g))
        rx_mem[g] <= (rx_ptr_q[1:0] == 2'd0) ? {24'h0, rx_byte}
                   : rx_mem[g] | ({24'h0, rx_byte} << {rx_ptr_q[1:0], 3'b000});
    end
  end

  // transmit buffer: word write pointer, byte read pointer
  logic [31:0] tx_mem [TXW];
  logic [TBW-2:0] tx_wp_q, tx_wp_d;
  logic [TBW:0]   tx_rp_q, tx_rp_d;
  logic tx_have, tx_wr;
  assign tx_have = tx_rp_q < {tx_wp_q, 2'b00};
  assign tx_wr   = tx_push && (tx_wp_q != (TBW-1)'(TXW)) && !tx_clr;
  assign tx_wp_d = tx_clr ? '0 : (tx_wr ? tx_wp_q + 1'b1 : tx_wp_q);
  assign tx_rp_d = tx_clr ? '0 : ((tx_pop && tx_have) ? tx_rp_q + 1'b1 : tx_rp_q);
  assign tx_byte = tx_have ? tx_mem[tx_rp_q[TBW-1:2]][{tx_rp_q[1:0], 3'b000} +: 8] : 8'h00;

  for (genvar g = 0; g < TXW; g++) begin : g_tx
    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) tx_mem[g] <= '0;
      else if (tx_wr && tx_wp_q == (TBW-1)'(g)) tx_mem[g] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rx_ptr_q <= '0;
      tx_wp_q  <= '0;
      tx_rp_q  <= '0;
    end else begin
      rx_ptr_q <= rx_ptr_d;
      tx_wp_q  <= tx_wp_d;
      tx_rp_q  <= tx_rp_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (tab_sel)     reg_rdata = lut_host;
    else if (rx_sel) reg_rdata = rx_mem[reg_addr[RBW-3:0]];
    else if (reg_addr == RA_FADDR) reg_rdata = faddr_q;
    else if (reg_addr == RA_STAT)
      reg_rdata = {28'h0, unlocked, (rx_ptr_q != '0), err_q, busy};
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic err,
  input logic cmd_we
);
  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk));
  // R9
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  // R9
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_we));
  // R10
  busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> err);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind flash_seq_engine flash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_s), .cs_n(spi_cs_n), .sclk(spi_sclk),
  .busy(busy), .err(err_q), .cmd_we(cmd_we)
);

// File: tb/flash_seq_engine_test.sv
module flash_seq_engine_test;
  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  flash_seq_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // flash model: known return stream, records all sent bits
  function automatic logic sbit(int k);
    automatic int j = k / 8;
    automatic logic [7:0] v = 8'((j * 29 + 91) & 255);
    return v[7 - (k % 8)];
  endfunction

  function automatic logic [7:0] sbyte(int off);
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++) v = {v[6:0], sbit(off + i)};
    return v;
  endfunction

  int fall_cnt = 0, fall_base = 0, rise_cnt = 0, cs_falls = 0, stray = 0;
  realtime t_prev = 0, t_last = 0;
  logic log_bits [65536];

  always @(negedge spi_sclk) fall_cnt++;
  always @(negedge spi_cs_n) begin fall_base = fall_cnt; cs_falls++; end
  always @(posedge spi_sclk) begin
    log_bits[rise_cnt & 16'hFFFF] = spi_mosi;
    rise_cnt++;
    if (spi_cs_n) stray++;
    t_prev = t_last;
    t_last = $realtime;
  end
  assign spi_miso = sbit(fall_cnt - fall_base);

  function automatic logic [31:0] got(int start, int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[30:0], log_bits[(start + i) & 16'hFFFF]};
    return v;
  endfunction

  function automatic logic [15:0] ins(int kind, int arg);
    return {6'(kind), 2'b00, 8'(arg)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  int base;
  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 20000; k++) begin
      rd(8'h05, s);
      if (!s[0]) break;
    end
  endtask

  task automatic run(input int seq, input int cnt);
    base = rise_cnt;
    wr(8'h04, (32'(seq) << 16) | 32'(cnt));
    wait_idle();
  endtask

  task automatic chk_rx(input int off, input int n, input string tag);
    logic [31:0] w, e;
    for (int q = 0; q < (n + 3) / 4; q++) begin
      e = '0;
      for (int b = 0; b < 4; b++)
        if (4 * q + b < n) e = e | (32'(sbyte(off + 8 * (4 * q + b))) << (8 * b));
      rd(8'h80 + 8'(q), w);
      chk(w == e, tag, w, e);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  logic [31:0] v, fa;
  logic [31:0] txw [16];
  int n, stray_before;

  initial begin
    void'($urandom(32'd4242));
    reg_we = 0; reg_addr = 0; reg_wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h05, v); chk(v == 0, "R1 status", v, 0);
    chk(spi_cs_n == 1 && spi_sclk == 0, "R1 pins", {spi_cs_n, spi_sclk}, 2'b10);
    rd(8'h48, v); chk(v == 0, "R1 table", v, 0);

    // R2 locked writes ignored, wrong key
    wr(8'h44, 32'h1234_5678); rd(8'h44, v); chk(v == 0, "R2 locked write", v, 0);
    wr(8'h01, 32'hDEAD_BEEF); wr(8'h02, 1); rd(8'h05, v); chk(v[3] == 0, "R2 bad key", v[3], 0);
    wr(8'h01, 32'h5AF0_C3A5); wr(8'h02, 1); rd(8'h05, v); chk(v[3] == 1, "R2 unlock", v[3], 1);

    // program sequences (R3 layout: seq s at 0x40 + 4s)
    wr(8'h44, {16'h0, ins(1, 8'h06)});
    wr(8'h48, {ins(2, 24), ins(1, 8'h0B)});
    wr(8'h49, {ins(4, 128), ins(3, 8)});
    wr(8'h4C, {ins(4, 1), ins(1, 8'h05)});
    wr(8'h50, {ins(2, 32), ins(1, 8'h0C)});
    wr(8'h51, {ins(4, 4), ins(3, 5)});
    for (int k = 0; k < 4; k++) wr(8'h54 + 8'(k), {ins(1, 8'hA1 + 2 * k), ins(1, 8'hA0 + 2 * k)});
    wr(8'h58, {ins(2, 24), ins(1, 8'h02)});
    wr(8'h59, {16'h0, ins(5, 64)});
    rd(8'h49, v); chk(v == {ins(4, 128), ins(3, 8)}, "R2 readback", v, {ins(4, 128), ins(3, 8)});
    wr(8'h01, 32'h5AF0_C3A5); wr(8'h02, 2); rd(8'h05, v); chk(v[3] == 0, "R2 relock", v[3], 0);
    wr(8'h49, 32'hFFFF_FFFF); rd(8'h49, v); chk(v == {ins(4, 128), ins(3, 8)}, "R2 relocked write", v, {ins(4, 128), ins(3, 8)});

    // R4 R9 single opcode, busy on command write, bit period
    base = rise_cnt; n = cs_falls;
    wr(8'h04, 32'h0001_0000); rd(8'h05, v); chk(v[0] == 1, "R9 busy set", v[0], 1);
    wait_idle();
    chk(rise_cnt - base == 8, "R3 opcode bits", rise_cnt - base, 8);
    chk(got(base, 8) == 8'h06, "R4 opcode", got(base, 8), 8'h06);
    chk(cs_falls - n == 1, "R9 one frame", cs_falls - n, 1);
    chk(t_last - t_prev == 80.0, "R9 bit period", longint'(t_last - t_prev), 80);

    // R4 R5 R6 full read with 24-bit address
    fa = $urandom; wr(8'h03, fa); wr(8'h00, 1);
    run(2, 0);
    chk(rise_cnt - base == 40 + 1024, "R5 frame bits", rise_cnt - base, 1064);
    chk(got(base, 8) == 8'h0B, "R4 read opcode", got(base, 8), 8'h0B);
    chk(got(base + 8, 24) == {8'h0, fa[23:0]}, "R4 addr24", got(base + 8, 24), fa[23:0]);
    chk(got(base + 32, 8) == 0, "R5 dummy low", got(base + 32, 8), 0);
    chk_rx(40, 128, "R6 read data");
    rd(8'h05, v); chk(v[2] == 1, "R6 avail", v[2], 1);

    // R11 R6 R3 clear then one-byte status read
    wr(8'h00, 1); rd(8'h05, v); chk(v[2] == 0, "R11 rx clear", v[2], 0);
    run(3, 0);
    chk(rise_cnt - base == 16, "R3 stop on zero", rise_cnt - base, 16);
    chk_rx(8, 1, "R6 pad one byte");

    // R8 count override with partial word
    wr(8'h00, 1); run(2, 5);
    chk(rise_cnt - base == 80, "R8 override bits", rise_cnt - base, 80);
    chk_rx(40, 5, "R8 override data");

    // R4 R5 32-bit address, 5 idle clocks
    fa = $urandom; wr(8'h03, fa); wr(8'h00, 1); run(4, 0);
    chk(got(base + 8, 32) == fa, "R4 addr32", got(base + 8, 32), fa);
    chk(rise_cnt - base == 8 + 32 + 5 + 32, "R5 dummy clocks", rise_cnt - base, 77);
    chk_rx(45, 4, "R5 read after dummy");

    // R3 eight slot sequence ends after slot 7
    run(5, 0);
    chk(rise_cnt - base == 64, "R3 slot limit", rise_cnt - base, 64);
    for (int k = 0; k < 8; k++) chk(got(base + 8 * k, 8) == 8'hA0 + k, "R3 slot order", got(base + 8 * k, 8), 8'hA0 + k);

    // R7 program 64 bytes
    wr(8'h00, 2);
    for (int k = 0; k < 16; k++) begin txw[k] = $urandom; wr(8'h06, txw[k]); end
    fa = $urandom; wr(8'h03, fa); run(6, 0);
    chk(rise_cnt - base == 32 + 512, "R7 frame bits", rise_cnt - base, 544);
    for (int k = 0; k < 64; k++)
      chk(got(base + 32 + 8 * k, 8) == 32'(txw[k / 4][8 * (k % 4) +: 8]), "R7 tx byte",
          got(base + 32 + 8 * k, 8), txw[k / 4][8 * (k % 4) +: 8]);

    // R11 R7 R8 empty transmit buffer sends zero bytes
    wr(8'h00, 2); run(6, 4);
    chk(rise_cnt - base == 64, "R8 write override", rise_cnt - base, 64);
    chk(got(base + 32, 32) == 0, "R11 tx clear zeros", got(base + 32, 32), 0);

    // R6 R8 random counts and addresses
    for (int r = 0; r < 6; r++) begin
      n = 1 + ($urandom % 128);
      fa = $urandom; wr(8'h03, fa); wr(8'h00, 1); run(2, n);
      chk(got(base + 8, 24) == {8'h0, fa[23:0]}, "R4 random addr", got(base + 8, 24), fa[23:0]);
      chk_rx(40, n, "R6 random read");
    end

    // R10 command while busy
    wr(8'h00, 1); base = rise_cnt;
    wr(8'h04, 32'h0002_0000);
    wr(8'h04, 32'h0001_0000);
    wait_idle();
    chk(rise_cnt - base == 1064, "R10 ignored cmd", rise_cnt - base, 1064);
    rd(8'h05, v); chk(v[1] == 1, "R10 err set", v[1], 1);
    run(1, 0); rd(8'h05, v); chk(v[1] == 1, "R10 err sticky", v[1], 1);
    chk(rise_cnt - base == 8, "R10 next cmd runs", rise_cnt - base, 8);

    // R9 idle pins and no clocks outside frames
    chk(spi_cs_n == 1 && spi_sclk == 0, "R9 idle pins", {spi_cs_n, spi_sclk}, 2'b10);
    chk(stray == 0, "R9 stray clocks", stray, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule